// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a 38-bit data-register scan chain. It gives an external debugger read and write access to a bank of 32-bit on-chip debug registers. The chain is driven by the capture, shift and update strobes of a TAP controller that sits outside the block. Each scan carries three fields: a register address, a data word and a direction flag. A write takes effect at update. A read is split across two scans. The scan that carries the address only records the request. The selected register is then loaded into the data field when the next scan captures, and it leaves through the serial output during that scan's shift phase.

The bank holds a debug control register, a debug status register, an optional vector-catch register and two watchpoint units of six registers each. It also holds a two-way message channel between the debugger and the core. The channel has a flag register and two data words, one for each direction. Consuming a word from the core clears its ready flag, so reading the channel data register is not idempotent. A debugger that wants a read result without a second side effect parks the address of the next scan on the channel flag register, which has no side effects. A plain core-side port deposits words for the debugger and takes words from it.

Top module: `dbg_scan_regs`

## Requirements
- R1: The chain is 38 bits long, and its bit 0 leaves `tdo_o` first. Frame bits [31:0] carry data, bits [36:32] the address and bit 37 the direction flag. A capture reloads only bits [31:0], so bits [37:32] of the previous frame come out unchanged at positions 32..37 of the next scan.
- R2: At update, a direction flag of 1 writes the data field into the addressed register. Debug control, bits [5:0], appears on `dbg_ctrl_o` and changes only at an update.
- R3: At update, a direction flag of 0 records a read request. The capture of the following scan loads that register into data bits [31:0]. A capture that follows a write scan loads zero.
- R4: The address map is: 0x00 debug control, 0x01 debug status, 0x02 vector catch, 0x04 channel flags, 0x05 channel data. Watchpoint unit 0 occupies 0x08–0x0D and unit 1 occupies 0x10–0x15. Each unit holds address value, address mask, data value, data mask, control value and control mask, in that order.
- R5: The channel flag register reads bit 0 as core-to-debugger ready, bit 1 as debugger-to-core busy, and bits [31:28] as the version (default 6). All other bits read as zero. Debugger writes to this register are ignored.
- R6: A core write (`core_wr_i`) stores a word and sets the ready flag. A captured debugger read of channel data returns that word and clears the ready flag. If both happen in the same cycle, the set wins and the old word is captured.
- R7: A debugger write to channel data sets the busy flag and presents the word on `core_rdata_o`. A `core_rd_i` pulse clears the busy flag. If both happen in the same cycle, the set wins.
- R8: Reading channel data is not idempotent: every captured read of it clears the ready flag again. Reading the channel flag register changes no state.
- R9: Debug control is 6 bits wide and debug status 10 bits wide. Their upper bits read as zero and ignore writes. Vector catch is 8 bits wide.
- R10: The vector-catch register exists only when `HAS_VCATCH` is 1. When it is absent, address 0x02 behaves as unmapped.
- R11: A read of an unmapped address (for example 0x03, 0x0E, 0x16 or 0x1F) returns zero. A write to one is ignored and corrupts no other register.
- R12: With `ir_sel_i` low, the capture, shift and update strobes have no effect.
- R13: A synchronous active-low reset clears every register and flag, including the chain. The version field is a constant and keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_sel_i | input | 1 | This chain's instruction is selected |
| capture_i | input | 1 | TAP is in the capture-DR state |
| shift_i | input | 1 | TAP is in the shift-DR state |
| update_i | input | 1 | TAP is in the update-DR state |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (chain bit 0) |
| core_wr_i | input | 1 | Core deposits a word for the debugger |
| core_wdata_i | input | 32 | Word deposited by the core |
| core_rd_i | input | 1 | Core takes the word from the debugger |
| core_rdata_o | output | 32 | Word last written by the debugger |
| rd_ready_o | output | 1 | Core-to-debugger word pending |
| wr_busy_o | output | 1 | Debugger-to-core word pending |
| dbg_ctrl_o | output | 6 | Debug control register |
| vcatch_o | output | 8 | Vector-catch register (zero when absent) |

## Verification
A table of write, read-request and park-on-flags scan triples covers every register class: full-width watchpoint words, narrow control and status words written with all ones, the read-only flag register, and unmapped holes. Together these separate correct address decoding and width truncation from aliasing. Directed scans check bit order and the fact that capture does not touch the upper frame bits. Back-to-back channel data reads, a core write that lands in the same cycle as the capture, and reads of the flag register separate a real side effect from an idempotent one. Scans run with the instruction deselected must leave every output unchanged.

// File: rtl/dbg_scan_pkg.sv
// Shared constants for the debug register scan chain.
// Assumes the frame layout is fixed: data low, address above, flag on top.
package dbg_scan_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int FRAME_W   = DATA_W + ADDR_W + 1;
    localparam int VER_W     = 4;
    localparam int WP_REGS   = 6;
    localparam int WP_STRIDE = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h01;
    localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
    localparam logic [ADDR_W-1:0] A_CFLAGS = 5'h04;
    localparam logic [ADDR_W-1:0] A_CDATA  = 5'h05;

    // Packed so that bit FRAME_W-1 is the flag and bits [DATA_W-1:0] the data.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
// Serial shift register of the chain.
// Capture loads only the data field. Shift moves one bit toward tdo.
// Assumes capture, shift and update are mutually exclusive TAP states.
module dbg_scan_shifter
    import dbg_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_data,
    output logic              tdo,
    output logic              cap_take,
    output logic              upd_valid,
    output frame_t            upd_frame
);
    logic [FRAME_W-1:0] sr_q;

    // Capture reloads the data field; shift feeds tdi in at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sel && capture) begin
            sr_q[DATA_W-1:0] <= cap_data;
        end else if (sel && shift) begin
            sr_q <= {tdi, sr_q[FRAME_W-1:1]};
        end
    end

    // Strobes seen by the rest of the block, gated by the instruction select.
    always_comb begin
        tdo       = sr_q[0];
        cap_take  = sel && capture;
        upd_valid = sel && update;
        upd_frame = frame_t'(sr_q);
    end
endmodule

// File: rtl/dbg_reg_bank.sv
// Plain debug registers: control, status, optional vector catch, watchpoints.
// Narrow registers keep only their low bits. Unmapped addresses read zero.
// Assumes addresses of the channel registers are handled by the caller.
module dbg_reg_bank
    import dbg_scan_pkg::*;
#(
    parameter int CTRL_W     = 6,
    parameter int STAT_W     = 10,
    parameter int VCATCH_W   = 8,
    parameter int NUM_WP     = 2,
    parameter bit HAS_VCATCH = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [DATA_W-1:0]   rdata,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [VCATCH_W-1:0] vcatch_o
);
    function automatic logic [ADDR_W-1:0] wp_addr(input int unit, input int idx);
        return ADDR_W'((unit + 1) * WP_STRIDE + idx);
    endfunction

    logic [CTRL_W-1:0]   ctrl_q;
    logic [STAT_W-1:0]   stat_q;
    logic [VCATCH_W-1:0] vc_q;
    logic [DATA_W-1:0]   wp_q [NUM_WP][WP_REGS];

    // Debug control and status registers, truncated to their widths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else if (we) begin
            if (waddr == A_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
            if (waddr == A_STAT) stat_q <= wdata[STAT_W-1:0];
        end
    end

    generate
        if (HAS_VCATCH) begin : g_vcatch
            // Vector-catch register, built only when requested.
            always_ff @(posedge clk) begin
                if (!rst_n)                         vc_q <= '0;
                else if (we && waddr == A_VCATCH)   vc_q <= wdata[VCATCH_W-1:0];
            end
        end else begin : g_no_vcatch
            assign vc_q = '0;
        end

        for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
            for (genvar r = 0; r < WP_REGS; r++) begin : g_reg
                // One full-width watchpoint register.
                always_ff @(posedge clk) begin
                    if (!rst_n)                          wp_q[u][r] <= '0;
                    else if (we && waddr == wp_addr(u, r)) wp_q[u][r] <= wdata;
                end
            end
        end
    endgenerate

    // Read mux: zero unless the address hits a register of this bank.
    always_comb begin
        rdata = '0;
        if (raddr == A_CTRL) rdata = DATA_W'(ctrl_q);
        if (raddr == A_STAT) rdata = DATA_W'(stat_q);
        if (HAS_VCATCH && raddr == A_VCATCH) rdata = DATA_W'(vc_q);
        for (int u = 0; u < NUM_WP; u++) begin
            for (int r = 0; r < WP_REGS; r++) begin
                if (raddr == wp_addr(u, r)) rdata = wp_q[u][r];
            end
        end
    end

    assign ctrl_o   = ctrl_q;
    assign vcatch_o = vc_q;
endmodule

// File: rtl/dbg_comm_channel.sv
// Two-way message channel between debugger and core.
// It holds the ready and busy flags and one data word for each direction.
// Assumes a set and a clear of the same flag in one cycle resolve to set.
module dbg_comm_channel
    import dbg_scan_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 4'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_wr,
    input  logic [DATA_W-1:0] dbg_wdata,
    input  logic              dbg_take,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_rd,
    output logic [DATA_W-1:0] to_dbg,
    output logic [DATA_W-1:0] flags_word,
    output logic [DATA_W-1:0] core_rdata,
    output logic              rd_ready,
    output logic              wr_busy
);
    logic [DATA_W-1:0] to_dbg_q, from_dbg_q;
    logic              ready_q, busy_q;

    // Core-to-debugger word and its ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_dbg_q <= '0;
            ready_q  <= 1'b0;
        end else if (core_wr) begin
            to_dbg_q <= core_wdata;
            ready_q  <= 1'b1;
        end else if (dbg_take) begin
            ready_q  <= 1'b0;
        end
    end

    // Debugger-to-core word and its busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_dbg_q <= '0;
            busy_q     <= 1'b0;
        end else if (dbg_wr) begin
            from_dbg_q <= dbg_wdata;
            busy_q     <= 1'b1;
        end else if (core_rd) begin
            busy_q     <= 1'b0;
        end
    end

    // Flag register view: version on top, flags at the bottom.
    always_comb begin
        flags_word = {VERSION, {(DATA_W - VER_W - 2){1'b0}}, busy_q, ready_q};
    end

    assign to_dbg     = to_dbg_q;
    assign core_rdata = from_dbg_q;
    assign rd_ready   = ready_q;
    assign wr_busy    = busy_q;
endmodule

// File: rtl/dbg_scan_regs.sv
// Top of the debug register scan chain.
// It decodes update frames into writes and read requests and keeps one
// pending read. At the next capture it picks the value to load.
// Assumes one TAP state strobe per cycle and a single clock domain.
module dbg_scan_regs
    import dbg_scan_pkg::*;
#(
    parameter int               CTRL_W       = 6,
    parameter int               STAT_W       = 10,
    parameter int               VCATCH_W     = 8,
    parameter int               NUM_WP       = 2,
    parameter bit               HAS_VCATCH   = 1'b1,
    parameter logic [VER_W-1:0] CHAN_VERSION = 4'd6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ir_sel_i,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                update_i,
    input  logic                tdi_i,
    output logic                tdo_o,
    input  logic                core_wr_i,
    input  logic [DATA_W-1:0]   core_wdata_i,
    input  logic                core_rd_i,
    output logic [DATA_W-1:0]   core_rdata_o,
    output logic                rd_ready_o,
    output logic                wr_busy_o,
    output logic [CTRL_W-1:0]   dbg_ctrl_o,
    output logic [VCATCH_W-1:0] vcatch_o
);
    logic              cap_take, upd_valid;
    frame_t            upd_frame;
    logic [DATA_W-1:0] cap_data, bank_rdata, to_dbg, flags_word;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              upd_wr, chan_wr, chan_take;

    dbg_scan_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (ir_sel_i),
        .capture   (capture_i),
        .shift     (shift_i),
        .update    (update_i),
        .tdi       (tdi_i),
        .cap_data  (cap_data),
        .tdo       (tdo_o),
        .cap_take  (cap_take),
        .upd_valid (upd_valid),
        .upd_frame (upd_frame)
    );

    // Pending read: set by a read frame at update, consumed at the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (upd_valid) begin
            pend_q      <= !upd_frame.wr;
            pend_addr_q <= upd_frame.addr;
        end else if (cap_take) begin
            pend_q      <= 1'b0;
        end
    end

    // Write decode and side-effect strobes for the channel.
    always_comb begin
        upd_wr    = upd_valid && upd_frame.wr;
        chan_wr   = upd_wr && (upd_frame.addr == A_CDATA);
        chan_take = cap_take && pend_q && (pend_addr_q == A_CDATA);
    end

    // Capture value: the pending register, or zero if no read is pending.
    always_comb begin
        cap_data = '0;
        if (pend_q) begin
            if (pend_addr_q == A_CDATA)       cap_data = to_dbg;
            else if (pend_addr_q == A_CFLAGS) cap_data = flags_word;
            else                              cap_data = bank_rdata;
        end
    end

    dbg_reg_bank #(
        .CTRL_W     (CTRL_W),
        .STAT_W     (STAT_W),
        .VCATCH_W   (VCATCH_W),
        .NUM_WP     (NUM_WP),
        .HAS_VCATCH (HAS_VCATCH)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (upd_wr),
        .waddr    (upd_frame.addr),
        .wdata    (upd_frame.data),
        .raddr    (pend_addr_q),
        .rdata    (bank_rdata),
        .ctrl_o   (dbg_ctrl_o),
        .vcatch_o (vcatch_o)
    );

    dbg_comm_channel #(
        .VERSION (CHAN_VERSION)
    ) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_wr     (chan_wr),
        .dbg_wdata  (upd_frame.data),
        .dbg_take   (chan_take),
        .core_wr    (core_wr_i),
        .core_wdata (core_wdata_i),
        .core_rd    (core_rd_i),
        .to_dbg     (to_dbg),
        .flags_word (flags_word),
        .core_rdata (core_rdata_o),
        .rd_ready   (rd_ready_o),
        .wr_busy    (wr_busy_o)
    );
endmodule

// File: rtl/dbg_scan_regs_chk.sv
// Protocol checker bound to the scan chain top; observes ports only.
module dbg_scan_regs_chk #(
    parameter int CTRL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ir_sel_i,
    input logic              capture_i,
    input logic              shift_i,
    input logic              update_i,
    input logic              core_wr_i,
    input logic              core_rd_i,
    input logic              tdo_o,
    input logic              rd_ready_o,
    input logic              wr_busy_o,
    input logic [CTRL_W-1:0] dbg_ctrl_o
);
    assert_core_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_i |=> rd_ready_o);

    assert_core_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd_i && !(ir_sel_i && update_i) |=> !wr_busy_o);

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ir_sel_i && update_i) && !core_rd_i |=> $stable(wr_busy_o));

    assert_ready_only_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !core_wr_i && !(ir_sel_i && capture_i) |=> $stable(rd_ready_o));

    assert_tdo_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ir_sel_i && (capture_i || shift_i)) |=> $stable(tdo_o));

    assert_ctrl_only_on_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ir_sel_i && update_i) |=> $stable(dbg_ctrl_o));

    assert_reset_clears_R13: assert property (@(posedge clk)
        !rst_n |=> (!rd_ready_o && !wr_busy_o && dbg_ctrl_o == '0 && !tdo_o));
endmodule

bind dbg_scan_regs dbg_scan_regs_chk #(.CTRL_W(CTRL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ir_sel_i   (ir_sel_i),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .update_i   (update_i),
    .core_wr_i  (core_wr_i),
    .core_rd_i  (core_rd_i),
    .tdo_o      (tdo_o),
    .rd_ready_o (rd_ready_o),
    .wr_busy_o  (wr_busy_o),
    .dbg_ctrl_o (dbg_ctrl_o)
);

// File: tb/dbg_scan_regs_tb.sv
module dbg_scan_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_sel_i = 1'b1, capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, tdi_i = 1'b0;
    logic        tdo_o;
    logic        core_wr_i = 1'b0, core_rd_i = 1'b0;
    logic [31:0] core_wdata_i = '0, core_rdata_o;
    logic        rd_ready_o, wr_busy_o;
    logic [5:0]  dbg_ctrl_o;
    logic [7:0]  vcatch_o;

    int errs = 0, checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_scan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .ir_sel_i(ir_sel_i), .capture_i(capture_i),
        .shift_i(shift_i), .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o),
        .core_wr_i(core_wr_i), .core_wdata_i(core_wdata_i), .core_rd_i(core_rd_i),
        .core_rdata_o(core_rdata_o), .rd_ready_o(rd_ready_o), .wr_busy_o(wr_busy_o),
        .dbg_ctrl_o(dbg_ctrl_o), .vcatch_o(vcatch_o)
    );

    // {address, written data, expected readback}
    localparam logic [68:0] VEC [NVEC] = '{
        {5'h00, 32'hFFFF_FFFF, 32'h0000_003F},  // R9 control width
        {5'h01, 32'hFFFF_FFFF, 32'h0000_03FF},  // R9 status width
        {5'h02, 32'hFFFF_FFFF, 32'h0000_00FF},  // R10 vector catch present
        {5'h08, 32'hA5A5_0001, 32'hA5A5_0001},  // R4 unit 0 first
        {5'h0B, 32'h8000_0001, 32'h8000_0001},  // R4
        {5'h0D, 32'h1234_5678, 32'h1234_5678},  // R4 unit 0 last
        {5'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4 unit 1 first
        {5'h15, 32'h0F0F_F0F0, 32'h0F0F_F0F0},  // R4 unit 1 last
        {5'h03, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {5'h0E, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {5'h16, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {5'h1F, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {5'h04, 32'hFFFF_FFFF, 32'h6000_0000}   // R5 flags read-only
    };

    task automatic chk(input string req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full scan: capture, 38 shifts (bit 0 first), update.
    task automatic scan(input logic sel, input logic [37:0] fin, input logic core_at_cap,
                        output logic [37:0] fout);
        @(negedge clk);
        ir_sel_i = sel; capture_i = 1'b1; core_wr_i = core_at_cap;
        @(negedge clk);
        capture_i = 1'b0; core_wr_i = 1'b0;
        for (int i = 0; i < 38; i++) begin
            shift_i = 1'b1; tdi_i = fin[i]; fout[i] = tdo_o;
            @(negedge clk);
        end
        shift_i = 1'b0; update_i = 1'b1;
        @(negedge clk);
        update_i = 1'b0; ir_sel_i = 1'b1;
    endtask

    function automatic logic [37:0] frm(input logic wr, input logic [4:0] a, input logic [31:0] d);
        return {wr, a, d};
    endfunction

    // Read via request scan + park-on-flags scan; returns the captured data.
    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        logic [37:0] o;
        scan(1'b1, frm(1'b0, a, 32'h0), 1'b0, o);
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b0, o);
        v = o[31:0];
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [37:0] o;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        chk("R13 reset outputs", {32'h0, tdo_o, rd_ready_o, wr_busy_o, dbg_ctrl_o[2:0]}, 38'h0);
        rd(5'h04, v);
        chk("R13 version after reset", v, 32'h6000_0000);

        // Table walk: write, read request, park
        for (int k = 0; k < NVEC; k++) begin
            scan(1'b1, frm(1'b1, VEC[k][68:64], VEC[k][63:32]), 1'b0, o);
            rd(VEC[k][68:64], v);
            chk($sformatf("R2/R4 table entry %0d", k), v, VEC[k][31:0]);
        end
        rd(5'h08, v);
        chk("R11 unmapped writes leave 0x08 intact", v, 32'hA5A5_0001);
        chk("R2 dbg_ctrl_o after write", dbg_ctrl_o, 6'h3F);

        // R3 capture after a write scan loads zero; R1 upper bits pass through
        scan(1'b1, frm(1'b1, 5'h00, 32'h0000_002A), 1'b0, o);
        chk("R2 dbg_ctrl_o value", dbg_ctrl_o, 6'h2A);
        scan(1'b1, frm(1'b0, 5'h13, 32'h0), 1'b0, o);
        chk("R3 capture after write is zero", o[31:0], 32'h0);
        chk("R1 upper bits of previous frame", o[37:32], 6'b1_00000);
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b0, o);
        chk("R1 upper bits after read frame", o[37:32], 6'b0_10011);

        // R6 channel core-to-debugger
        @(negedge clk); core_wr_i = 1'b1; core_wdata_i = 32'hCAFE_0123;
        @(negedge clk); core_wr_i = 1'b0;
        chk("R6 ready set by core write", rd_ready_o, 1'b1);
        rd(5'h05, v);
        chk("R6 data read", v, 32'hCAFE_0123);
        chk("R6 ready cleared by read", rd_ready_o, 1'b0);
        rd(5'h04, v);
        chk("R8 flags show ready clear", v, 32'h6000_0000);

        // R8 flags read is idempotent
        @(negedge clk); core_wr_i = 1'b1; core_wdata_i = 32'h0000_BEEF;
        @(negedge clk); core_wr_i = 1'b0;
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b0, o);
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b0, o);
        chk("R8 first flags read", o[31:0], 32'h6000_0001);
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b0, o);
        chk("R8 second flags read", o[31:0], 32'h6000_0001);
        chk("R8 ready kept", rd_ready_o, 1'b1);

        // R8 repeated data read clears again
        scan(1'b1, frm(1'b0, 5'h05, 32'h0), 1'b0, o);
        scan(1'b1, frm(1'b0, 5'h05, 32'h0), 1'b0, o);
        chk("R8 first data read", o[31:0], 32'h0000_BEEF);
        @(negedge clk); core_wr_i = 1'b1; core_wdata_i = 32'h0000_F00D;
        @(negedge clk); core_wr_i = 1'b0;
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b0, o);
        chk("R8 second data read", o[31:0], 32'h0000_F00D);
        chk("R8 second read cleared ready", rd_ready_o, 1'b0);

        // R6 core write coincident with capture: set wins, old word captured
        scan(1'b1, frm(1'b0, 5'h05, 32'h0), 1'b0, o);
        core_wdata_i = 32'h7777_0000;
        scan(1'b1, frm(1'b0, 5'h04, 32'h0), 1'b1, o);
        chk("R6 coincident capture gets old word", o[31:0], 32'h0000_F00D);
        chk("R6 coincident set wins", rd_ready_o, 1'b1);

        // R7 debugger-to-core
        scan(1'b1, frm(1'b1, 5'h05, 32'h1357_9BDF), 1'b0, o);
        chk("R7 busy set", wr_busy_o, 1'b1);
        chk("R7 core sees word", core_rdata_o, 32'h1357_9BDF);
        rd(5'h04, v);
        chk("R7 flags show busy", v, 32'h6000_0003);
        @(negedge clk); core_rd_i = 1'b1;
        @(negedge clk); core_rd_i = 1'b0;
        chk("R7 busy cleared by core read", wr_busy_o, 1'b0);

        // R12 deselected scans have no effect
        scan(1'b0, frm(1'b1, 5'h00, 32'h0000_0015), 1'b0, o);
        chk("R12 ctrl unchanged when deselected", dbg_ctrl_o, 6'h2A);
        rd(5'h00, v);
        chk("R12 ctrl readback unchanged", v, 32'h0000_002A);

        // R10 vector catch output
        scan(1'b1, frm(1'b1, 5'h02, 32'h0000_0155), 1'b0, o);
        chk("R10 vcatch_o", vcatch_o, 8'h55);

        // R13 reset clears registers, keeps version
        do_reset();
        chk("R13 ctrl after reset", dbg_ctrl_o, 6'h0);
        chk("R13 ready after reset", rd_ready_o, 1'b0);
        rd(5'h10, v);
        chk("R13 watchpoint cleared", v, 32'h0);
        rd(5'h04, v);
        chk("R13 version kept", v, 32'h6000_0000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule